// File: doc/BRIEF.md
# Streaming Table Lookup Engine

This block turns a stream of byte addresses into a stream of byte results. It reads each address from a first-word-fall-through input queue and issues a read for it to an external single-port table of 256 bytes. It then pushes the returned byte into an output queue. The table answers a fixed three cycles after the read is presented. The engine therefore keeps up to three reads in flight and sustains one lookup per clock when the input has data and the output has room.

A three-bit valid shift register marks the cycles in which real data comes back from the table. When the output can take a result, a returning byte goes straight to the output. When the output is full, or when older results are still waiting, the byte goes into a small result buffer. New addresses are taken only while the in-flight reads plus the buffered results stay below the buffer depth. Because of this rule, data that comes back during output backpressure always has a place to go. Results leave in the order their addresses were taken.

Top module: `lookup_stream_engine`

## Requirements
- R1: While the synchronous active-high reset is asserted, no address is popped, no table read is issued, and no result is written. The valid bits, the buffer pointers and the buffer occupancy are cleared.
- R2: The table chip enable and the input pop strobe are high in exactly the same cycles. In those cycles the table address equals the input token.
- R3: Each result byte equals the table content at the address that produced it. The table returns data exactly three cycles after the read.
- R4: Results are written in the order in which their addresses were accepted.
- R5: When the input is not empty and the output is never full, an address is accepted in every cycle.
- R6: When the output is not stalled, the result for an address accepted in cycle t is written in cycle t+3.
- R7: The result write strobe is never high in a cycle where the output full flag is high.
- R8: While the output stays full and input is available, the engine accepts exactly as many addresses as the buffer depth (4 by default) and then stops. It drops no data, and every accepted address produces a result once the output drains.
- R9: No address is popped and no table read is issued in a cycle where the input empty flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_empty | input | 1 | Input queue has no token |
| in_data | input | 8 | Head token of the input queue (table address) |
| in_rd | output | 1 | Pop strobe for the input queue |
| mem_ce | output | 1 | Table read enable |
| mem_addr | output | 8 | Table read address |
| mem_rdata | input | 8 | Table read data, valid three cycles after the read |
| out_full | input | 1 | Output queue cannot accept a result |
| out_wr | output | 1 | Push strobe for the output queue |
| out_data | output | 8 | Result byte |

## Verification
The bench runs every one of the 256 table addresses through the engine while the input and output flags follow an irregular pattern. The main risk in that case is a bypass-versus-buffer ordering error, which would swap or repeat results. A long output stall with input pending checks the admission limit. An engine whose credit ignores in-flight reads would accept a fifth address and then drop or overwrite a returning byte. An engine that leaves bubbles shows up in the free-running run as a missed pop or as a latency other than three cycles. Gapped input shows whether a read is ever issued from an empty queue.

// File: rtl/lse_pkg.sv
package lse_pkg;

    localparam int LSE_ADDR_W  = 8;
    localparam int LSE_DATA_W  = 8;
    localparam int LSE_MEM_LAT = 3;

    typedef logic [LSE_ADDR_W-1:0] lse_addr_t;
    typedef logic [LSE_DATA_W-1:0] lse_data_t;

    // a byte coming back from the table, tagged with its valid mark
    typedef struct packed {
        logic      vld;
        lse_data_t data;
    } lse_ret_t;

    // where the output byte comes from in a given cycle
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_BUFFER = 2'd2
    } lse_src_e;

    function automatic logic [5:0] lse_ones(input logic [31:0] v);
        logic [5:0] n;
        n = '0;
        for (int i = 0; i < 32; i++) n = n + 6'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/lse_issue.sv
module lse_issue
    import lse_pkg::*;
#(
    parameter int LAT   = LSE_MEM_LAT,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_empty,
    input  logic [CNT_W-1:0] occ,
    output logic             accept,
    output logic             ret_vld
);

    logic [LAT-1:0] vld_sr;
    logic [5:0]     inflight;

    assign inflight = lse_ones(32'(vld_sr));
    assign accept   = !rst && !in_empty && ((int'(inflight) + int'(occ)) < DEPTH);
    assign ret_vld  = vld_sr[LAT-1];

    always_ff @(posedge clk) begin
        if (rst) vld_sr <= '0;
        else     vld_sr <= {vld_sr[LAT-2:0], accept};
    end

    p_total_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(inflight) + int'(occ)) <= DEPTH);

    p_no_read_when_empty_r9: assert property (@(posedge clk) disable iff (rst)
        in_empty |-> !accept);

    p_fixed_return_r3: assert property (@(posedge clk) disable iff (rst)
        ret_vld == $past(accept, 3));

endmodule

// File: rtl/lse_result_buf.sv
module lse_result_buf
    import lse_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  lse_data_t        push_data,
    input  logic             pop,
    output lse_data_t        head,
    output logic [CNT_W-1:0] count,
    output logic             empty
);

    lse_data_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop) rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        push |-> (int'(count) < DEPTH) || pop);

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/lookup_stream_engine.sv
module lookup_stream_engine
    import lse_pkg::*;
#(
    parameter int BUF_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_empty,
    input  logic [LSE_ADDR_W-1:0] in_data,
    output logic                  in_rd,
    output logic                  mem_ce,
    output logic [LSE_ADDR_W-1:0] mem_addr,
    input  logic [LSE_DATA_W-1:0] mem_rdata,
    input  logic                  out_full,
    output logic                  out_wr,
    output logic [LSE_DATA_W-1:0] out_data
);

    localparam int CNT_W = $clog2(BUF_DEPTH + 1);

    logic             accept;
    lse_ret_t         ret;
    logic             ret_vld;
    logic [CNT_W-1:0] occ;
    logic             buf_empty;
    lse_data_t        buf_head;
    logic             buf_push, buf_pop;
    lse_src_e         src;

    lse_issue #(.LAT(LSE_MEM_LAT), .DEPTH(BUF_DEPTH)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .in_empty (in_empty),
        .occ      (occ),
        .accept   (accept),
        .ret_vld  (ret_vld)
    );

    assign ret.vld  = ret_vld;
    assign ret.data = mem_rdata;

    // older buffered results go first; a return bypasses only an empty buffer
    always_comb begin
        src = SRC_NONE;
        if (!out_full) begin
            if (!buf_empty)   src = SRC_BUFFER;
            else if (ret.vld) src = SRC_BYPASS;
        end
    end

    assign buf_pop  = (src == SRC_BUFFER);
    assign buf_push = ret.vld && (src != SRC_BYPASS);

    lse_result_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (buf_push),
        .push_data (ret.data),
        .pop       (buf_pop),
        .head      (buf_head),
        .count     (occ),
        .empty     (buf_empty)
    );

    assign in_rd    = accept;
    assign mem_ce   = accept;
    assign mem_addr = in_data;
    assign out_wr   = (src != SRC_NONE);
    assign out_data = (src == SRC_BUFFER) ? buf_head : ret.data;

    p_no_write_when_full_r7: assert property (@(posedge clk) disable iff (rst)
        out_full |-> !out_wr);

    p_ce_tracks_pop_r2: assert property (@(posedge clk) disable iff (rst)
        mem_ce == in_rd);

    always @(posedge clk) begin
        if (rst) begin
            p_quiet_in_reset_r1: assert (!mem_ce && !in_rd);
        end
    end

endmodule

// File: tb/lookup_stream_engine_bench.sv
`timescale 1ns/1ps
module lookup_stream_engine_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_empty;
    logic [7:0] in_data;
    logic       in_rd;
    logic       mem_ce;
    logic [7:0] mem_addr;
    logic [7:0] mem_rdata;
    logic       out_full;
    logic       out_wr;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    lookup_stream_engine u_lookup_stream_engine (
        .clk(clk), .rst(rst), .in_empty(in_empty), .in_data(in_data),
        .in_rd(in_rd), .mem_ce(mem_ce), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .out_full(out_full), .out_wr(out_wr),
        .out_data(out_data)
    );

    function automatic logic [7:0] tbl(input logic [7:0] a);
        return 8'((int'(a) * 37 + 11) & 255);
    endfunction

    // behavioural table: request latched mid-cycle, three register stages
    logic       req_ce;
    logic [7:0] req_a;
    logic [7:0] st1, st2;
    always @(negedge clk) begin
        req_ce <= mem_ce;
        req_a  <= mem_addr;
    end
    always @(posedge clk) begin
        st1       <= req_ce ? tbl(req_a) : 8'hxx;
        st2       <= st1;
        mem_rdata <= st2;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    logic [7:0] exp_addr [512];
    int         acc_cyc  [512];

    task automatic run_phase(input int n, input int base, input int stp,
                             input int emode, input int fmode, input bit chk_lat);
        int sent = 0, widx = 0, ridx = 0, pc = 0, acc_full = 0;
        while (!(sent == n && ridx == widx)) begin
            logic gap;
            gap = (emode == 1) && (pc % 3 == 2);
            in_empty = (sent >= n) || gap;
            in_data  = 8'((base + sent * stp) & 255);
            case (fmode)
                1:       out_full = (pc % 4 == 1) || (pc % 5 == 0);
                2:       out_full = (pc < 12);
                default: out_full = 1'b0;
            endcase
            @(negedge clk);
            check(mem_ce == in_rd, "R2 ce/pop", mem_ce, in_rd);
            if (in_rd) check(mem_addr == in_data, "R2 addr", mem_addr, in_data);
            if (in_empty) check(!in_rd && !mem_ce, "R9 read while empty", in_rd, 0);
            if (out_full) check(!out_wr, "R7 write while full", out_wr, 0);
            if (emode == 0 && fmode == 0 && !in_empty)
                check(in_rd, "R5 bubble", in_rd, 1);
            if (in_rd) begin
                exp_addr[widx] = in_data;
                acc_cyc[widx]  = cyc;
                widx++;
                sent++;
                if (fmode == 2 && pc < 12) acc_full++;
            end
            if (out_wr) begin
                if (ridx >= widx) begin
                    check(0, "R4 extra result", ridx, widx);
                end else begin
                    check(out_data == tbl(exp_addr[ridx]), "R3/R4 data",
                          out_data, tbl(exp_addr[ridx]));
                    if (chk_lat)
                        check(cyc - acc_cyc[ridx] == 3, "R6 latency",
                              cyc - acc_cyc[ridx], 3);
                    ridx++;
                end
            end
            @(posedge clk); #1;
            cyc++;
            pc++;
            if (pc > 5000) begin
                check(0, "watchdog phase", pc, 5000);
                break;
            end
        end
        check(ridx == n, "R8 all results delivered", ridx, n);
        if (fmode == 2) check(acc_full == 4, "R8 admission limit", acc_full, 4);
        in_empty = 1'b1;
        out_full = 1'b0;
    endtask

    initial begin
        rst = 1'b1; in_empty = 1'b0; in_data = 8'h11; out_full = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(!in_rd && !mem_ce, "R1 no read in reset", in_rd, 0);
        check(!out_wr, "R1 no write in reset", out_wr, 0);
        @(posedge clk); #1;
        rst = 1'b0; in_empty = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        @(negedge clk);
        check(!out_wr, "R1 nothing pending after reset", out_wr, 0);
        @(posedge clk); #1;

        run_phase(64,  0,   1, 0, 0, 1);   // free running
        run_phase(64,  200, 3, 1, 0, 1);   // gapped input
        run_phase(20,  7,   5, 0, 2, 0);   // long output stall
        run_phase(256, 0,   1, 1, 1, 0);   // all addresses, mixed flags
        run_phase(256, 128, 1, 0, 1, 0);   // all addresses, stalls only

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule